// File: doc/BRIEF.md
# Preset Checking-Experiment Sequencer

This block runs a complete, non-adaptive checking experiment against a finite-state machine under test. That machine has two extra test symbols. Each one shifts its `P`-bit state code right by one place, with the new top bit taken from the symbol. The machine's output under a test symbol is the code bit that falls off the bottom. Because of this structure, `P` symbols of one kind synchronise the machine from any state and also distinguish every state.

The block emits one symbol per active cycle. In order, it first synchronises the machine. It then visits every state and checks that state's response and the return response. It then applies every specified ordinary transition and identifies the resulting state. Per instance, the specified transitions arrive as constant table ports. The block keeps its own model of the machine, so it knows the expected output of every symbol. It compares that value with the observed output in the same cycle and holds a sticky failure flag.

Top module: `chkexp_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `sym_valid` are all low.
- R2: Symbol codes are as follows. A value `j` below `M` is ordinary input `j`. `M` shifts in a 0 and `M+1` shifts in a 1. `sym_valid` is high exactly in the cycles in which a symbol is to be applied.
- R3: The first `P` symbols after an accepted `start` all shift in 0, whatever state the machine starts from. Their outputs are not compared.
- R4: Next, for each state code `i` from 0 up to `2^P-1`, the block applies the transfer to `i` followed by `2P` shift-in-0 symbols.
- R5: The transfer to code `i` applies bits `k` of `i` as shift-in-`i[k]` symbols. It starts at the lowest set bit of `i` and runs up to bit `P-1`. For `i = 0` the transfer is empty.
- R6: Last comes the transition phase. Pairs run with state `i` in the outer loop and input `j` ascending in the inner loop. A pair is applied if its output or its next state is specified, at table bit `i*M+j`. The block applies the transfer to `i`, then `j`, then `P` shift-in-0 symbols. A fully unspecified pair emits no symbol.
- R7: The expected output of a shift symbol is bit 0 of the modelled code. The expected output of input `j` is `tbl_out[i*M+j]`, and the next code is `tbl_next[(i*M+j)*P +: P]`. An output is compared only when it is both specified and determined by known state.
- R8: `fail` rises on the first compared mismatch. It stays high until the next accepted `start` clears it.
- R9: `busy` is high from the cycle after an accepted `start` until the final symbol. After that, `done` is high for exactly one cycle with `busy` low.
- R10: A `start` seen while `busy` is high is ignored.
- R11: The experiment length never exceeds `(3n+1)P + mn(2P+1)` symbols, where `n = 2^P`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted while idle |
| obs | input | 1 | Output of the machine under test for the current symbol |
| tbl_next | input | 2^P*M*P | Specified next code per (state, input) |
| tbl_out | input | 2^P*M | Specified output per (state, input) |
| tbl_out_ok | input | 2^P*M | Output of the pair is specified |
| tbl_next_ok | input | 2^P*M | Next state of the pair is specified |
| sym | output | clog2(M+2) | Symbol to apply |
| sym_valid | output | 1 | A symbol is applied this cycle |
| busy | output | 1 | Experiment in progress |
| done | output | 1 | One-cycle end pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with `P = 2` and `M = 2`, giving four states and eight table entries. At this size the whole symbol stream can be predicted and compared symbol by symbol. The table mixes fully specified pairs, a pair with only its output specified, and fully unspecified pairs. This covers every compare, skip and don't-care path. The same size makes an exhaustive fault sweep practical: every specified output flip, every specified next-state corruption, and every shift-output flip is injected in turn. Each of these must raise `fail`, while a fault on a skipped pair must not.

// File: rtl/chkexp_pkg.sv
package chkexp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_XFER,
    PH_DIST,
    PH_INPT,
    PH_PICK,
    PH_FIN
  } ph_t;

  // index of the lowest set bit, 0 when none is set
  function automatic int lowest_one(input logic [31:0] v);
    int r;
    r = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

endpackage

// File: rtl/chkexp_ctrl.sv
module chkexp_ctrl import chkexp_pkg::*; #(
  parameter int P = 2,
  parameter int M = 2,
  localparam int N  = 1 << P,
  localparam int SW = $clog2(M + 2),
  localparam int JW = (M > 1) ? $clog2(M) : 1,
  localparam int CW = $clog2(2 * P) + 1,
  localparam int TW = $clog2(N * M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N*M-1:0] spec_chk,
  output logic [SW-1:0] sym,
  output logic          valid,
  output logic          busy,
  output logic          done,
  output logic          launch
);

  localparam logic [SW-1:0] E0 = SW'(M);
  localparam logic [SW-1:0] E1 = SW'(M + 1);

  ph_t            ph_q, ph_d;
  logic           partb_q, partb_d;
  logic [P-1:0]   si_q, si_d;
  logic [JW-1:0]  sj_q, sj_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  logic [TW-1:0]  pidx;
  logic [P-1:0]   si_inc, shx;
  logic           last_st, last_j, xbit;
  logic [CW-1:0]  dist_lim;
  ph_t            adv_ph;
  logic [P-1:0]   adv_si;
  logic [JW-1:0]  adv_sj;

  assign pidx     = TW'(si_q) * TW'(M) + TW'(sj_q);
  assign si_inc   = si_q + 1'b1;
  assign last_st  = &si_q;
  assign last_j   = (sj_q == JW'(M - 1));
  assign shx      = si_q >> cnt_q;
  assign xbit     = shx[0];
  assign dist_lim = partb_q ? CW'(P - 1) : CW'(2 * P - 1);

  // step to the next (state, input) pair of the transition phase
  always_comb begin
    adv_si = si_q;
    adv_sj = sj_q + 1'b1;
    adv_ph = PH_PICK;
    if (last_j) begin
      adv_sj = '0;
      if (last_st) adv_ph = PH_FIN;
      else         adv_si = si_inc;
    end
  end

  always_comb begin
    ph_d    = ph_q;
    partb_d = partb_q;
    si_d    = si_q;
    sj_d    = sj_q;
    cnt_d   = cnt_q;
    sym     = '0;
    valid   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d    = PH_SYNC;
          partb_d = 1'b0;
          si_d    = '0;
          sj_d    = '0;
          cnt_d   = '0;
        end
      end
      PH_SYNC: begin
        valid = 1'b1;
        sym   = E0;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(P - 1)) begin
          ph_d  = PH_DIST;
          cnt_d = '0;
        end
      end
      PH_XFER: begin
        valid = 1'b1;
        sym   = xbit ? E1 : E0;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(P - 1)) begin
          ph_d  = partb_q ? PH_INPT : PH_DIST;
          cnt_d = '0;
        end
      end
      PH_DIST: begin
        valid = 1'b1;
        sym   = E0;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == dist_lim) begin
          cnt_d = '0;
          if (!partb_q) begin
            if (last_st) begin
              partb_d = 1'b1;
              si_d    = '0;
              sj_d    = '0;
              ph_d    = PH_PICK;
            end else begin
              si_d  = si_inc;
              ph_d  = PH_XFER;
              cnt_d = CW'(lowest_one(32'(si_inc)));
            end
          end else begin
            ph_d = adv_ph;
            si_d = adv_si;
            sj_d = adv_sj;
          end
        end
      end
      PH_INPT: begin
        valid = 1'b1;
        sym   = SW'(sj_q);
        ph_d  = PH_DIST;
        cnt_d = '0;
      end
      PH_PICK: begin
        if (spec_chk[pidx]) begin
          if (si_q == '0) begin
            ph_d = PH_INPT;
          end else begin
            ph_d  = PH_XFER;
            cnt_d = CW'(lowest_one(32'(si_q)));
          end
        end else begin
          ph_d = adv_ph;
          si_d = adv_si;
          sj_d = adv_sj;
        end
      end
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      partb_q <= 1'b0;
      si_q    <= '0;
      sj_q    <= '0;
      cnt_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      partb_q <= partb_d;
      si_q    <= si_d;
      sj_q    <= sj_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy   = (ph_q != PH_IDLE) && (ph_q != PH_FIN);
  assign done   = (ph_q == PH_FIN);
  assign launch = (ph_q == PH_IDLE) && start;

  assert_first_sym_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (valid && sym == E0));
  assert_sym_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (busy && sym <= E1));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_no_relaunch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !launch);

endmodule

// File: rtl/chkexp_model.sv
module chkexp_model #(
  parameter int P = 2,
  parameter int M = 2,
  localparam int N  = 1 << P,
  localparam int SW = $clog2(M + 2),
  localparam int TW = $clog2(N * M)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [SW-1:0]   sym,
  input  logic            valid,
  input  logic [N*M*P-1:0] spec_next,
  input  logic [N*M-1:0]  spec_out,
  input  logic [N*M-1:0]  spec_out_ok,
  input  logic [N*M-1:0]  spec_nxt_ok,
  output logic            exp_bit,
  output logic            care
);

  logic [P-1:0]  mst_q, mst_d;
  logic [P-1:0]  kn_q, kn_d;
  logic [TW-1:0] idx;
  logic          is_shift, shift_one, full;

  assign is_shift  = (sym >= SW'(M));
  assign shift_one = (sym == SW'(M + 1));
  assign full      = &kn_q;
  assign idx       = TW'(mst_q) * TW'(M) + TW'(sym);

  always_comb begin
    if (is_shift) begin
      exp_bit = mst_q[0];
      care    = kn_q[0];
      mst_d   = (mst_q >> 1) | (P'(shift_one) << (P - 1));
      kn_d    = (kn_q >> 1) | (P'(1) << (P - 1));
    end else begin
      exp_bit = spec_out[idx];
      care    = full & spec_out_ok[idx];
      mst_d   = spec_next[idx*P +: P];
      kn_d    = (full & spec_nxt_ok[idx]) ? '1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= '0;
      kn_q  <= '0;
    end else if (launch) begin
      kn_q  <= '0;
    end else if (valid) begin
      mst_q <= mst_d;
      kn_q  <= kn_d;
    end
  end

  assert_shift_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !launch && sym == SW'(M)) |=> (!mst_q[P-1] && kn_q[P-1]));
  assert_fresh_unknown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (kn_q == '0));

endmodule

// File: rtl/chkexp_flag.sv
module chkexp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic valid,
  input  logic care,
  input  logic exp_bit,
  input  logic obs,
  output logic fail
);

  logic fail_d;

  always_comb begin
    if (clr) fail_d = 1'b0;
    else     fail_d = fail | (valid & care & (obs != exp_bit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail <= 1'b0;
    else        fail <= fail_d;
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);
  assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(valid && care && obs != exp_bit));

endmodule

// File: rtl/chkexp_seq.sv
module chkexp_seq #(
  parameter int P = 2,
  parameter int M = 2,
  localparam int N  = 1 << P,
  localparam int SW = $clog2(M + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             obs,
  input  logic [N*M*P-1:0] tbl_next,
  input  logic [N*M-1:0]   tbl_out,
  input  logic [N*M-1:0]   tbl_out_ok,
  input  logic [N*M-1:0]   tbl_next_ok,
  output logic [SW-1:0]    sym,
  output logic             sym_valid,
  output logic             busy,
  output logic             done,
  output logic             fail
);

  logic launch, exp_bit, care;

  chkexp_ctrl #(.P(P), .M(M)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .spec_chk(tbl_out_ok | tbl_next_ok),
    .sym(sym), .valid(sym_valid), .busy(busy), .done(done), .launch(launch)
  );

  chkexp_model #(.P(P), .M(M)) model_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .sym(sym), .valid(sym_valid),
    .spec_next(tbl_next), .spec_out(tbl_out), .spec_out_ok(tbl_out_ok),
    .spec_nxt_ok(tbl_next_ok), .exp_bit(exp_bit), .care(care)
  );

  chkexp_flag flag_i (
    .clk(clk), .rst_n(rst_n), .clr(launch), .valid(sym_valid), .care(care),
    .exp_bit(exp_bit), .obs(obs), .fail(fail)
  );

endmodule

// File: tb/chkexp_seq_tb_top.sv
module chkexp_seq_tb_top;

  localparam int P  = 2;
  localparam int M  = 2;
  localparam int N  = 1 << P;
  localparam int SW = $clog2(M + 2);
  localparam int E0 = M;
  localparam int E1 = M + 1;

  logic clk, rst_n, start, obs;
  logic [N*M*P-1:0] tbl_next;
  logic [N*M-1:0]   tbl_out, tbl_out_ok, tbl_next_ok;
  logic [SW-1:0]    sym;
  logic sym_valid, busy, done, fail;

  chkexp_seq #(.P(P), .M(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .obs(obs),
    .tbl_next(tbl_next), .tbl_out(tbl_out), .tbl_out_ok(tbl_out_ok),
    .tbl_next_ok(tbl_next_ok), .sym(sym), .sym_valid(sym_valid),
    .busy(busy), .done(done), .fail(fail)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural machine under test with injectable faults
  // fault kind: 0 none, 1 flip ordinary output, 2 corrupt ordinary next, 3 flip shift-in-0 output
  int f_kind = 0;
  int f_idx  = 0;
  int f_st   = 0;
  logic [P-1:0] m_st;
  logic pre_req;
  logic [P-1:0] pre_val;

  always_comb begin
    int ix;
    ix = int'(m_st) * M + int'(sym);
    if (int'(sym) >= M) begin
      obs = m_st[0];
      if (f_kind == 3 && int'(m_st) == f_st && int'(sym) == E0) obs = ~obs;
    end else begin
      obs = tbl_out[ix];
      if (f_kind == 1 && ix == f_idx) obs = ~obs;
    end
  end

  always @(posedge clk) begin
    int ix;
    logic [P-1:0] nx;
    ix = int'(m_st) * M + int'(sym);
    if (pre_req) m_st <= pre_val;
    else if (sym_valid) begin
      if (int'(sym) >= M)
        m_st <= (m_st >> 1) | (P'(int'(sym) == E1) << (P - 1));
      else begin
        nx = tbl_next[ix*P +: P];
        if (f_kind == 2 && ix == f_idx) nx = nx ^ P'(1);
        m_st <= nx;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // expected stream, built from the requirements
  int exp_sym [0:127];
  int exp_len;

  function automatic int low_set(input int v);
    for (int k = 0; k < P; k++) if (((v >> k) & 1) == 1) return k;
    return 0;
  endfunction

  task automatic push_xfer(input int i);
    if (i != 0)
      for (int k = low_set(i); k < P; k++) begin
        exp_sym[exp_len] = (((i >> k) & 1) == 1) ? E1 : E0;
        exp_len++;
      end
  endtask

  task automatic build_stream();
    exp_len = 0;
    for (int k = 0; k < P; k++) begin exp_sym[exp_len] = E0; exp_len++; end
    for (int i = 0; i < N; i++) begin
      push_xfer(i);
      for (int k = 0; k < 2 * P; k++) begin exp_sym[exp_len] = E0; exp_len++; end
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++)
        if (tbl_out_ok[i*M+j] || tbl_next_ok[i*M+j]) begin
          push_xfer(i);
          exp_sym[exp_len] = j; exp_len++;
          for (int k = 0; k < P; k++) begin exp_sym[exp_len] = E0; exp_len++; end
        end
  endtask

  int r_len, r_done, r_badpos, r_sync_bad;
  bit r_wd, r_busy0;

  task automatic run_exp(input int init_st, input bit mid_start);
    int cyc;
    r_len = 0; r_done = 0; r_badpos = -1; r_sync_bad = 0; r_wd = 0; cyc = 0;
    @(negedge clk);
    pre_val = P'(init_st); pre_req = 1'b1; start = 1'b1;
    @(negedge clk);
    pre_req = 1'b0; start = 1'b0;
    r_busy0 = busy;
    forever begin
      if (sym_valid) begin
        if (r_len < 128 && int'(sym) != exp_sym[r_len] && r_badpos < 0) r_badpos = r_len;
        if (r_len < P && int'(sym) != E0) r_sync_bad++;
        r_len++;
      end
      if (done) begin
        r_done++;
        if (busy) r_done += 100;
        break;
      end
      cyc++;
      start = (mid_start && (cyc == 9 || cyc == 10));
      if (cyc > 3000) begin r_wd = 1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    if (done) r_done++;
    check(!r_wd, "R9 watchdog", 0, 1);
  endtask

  initial begin
    int bound;
    start = 1'b0; pre_req = 1'b0; pre_val = '0; rst_n = 1'b0;
    tbl_next    = 16'h0181;
    tbl_out     = 8'b0010_0011;
    tbl_out_ok  = 8'b0011_1011;
    tbl_next_ok = 8'b0001_1011;
    build_stream();
    bound = (3 * N + 1) * P + M * N * (2 * P + 1);
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !sym_valid, "R1 reset outputs",
          {busy, done, fail, sym_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // clean runs from every start state
    for (int s = 0; s < N; s++) begin
      f_kind = 0;
      run_exp(s, 0);
      check(r_busy0 == 1'b1, "R9 busy after start", r_busy0, 1);
      check(r_sync_bad == 0, "R3 sync symbols", r_sync_bad, 0);
      check(r_badpos < 0, "R4 R5 R6 symbol stream position", r_badpos, -1);
      check(r_len == exp_len, "R6 stream length", r_len, exp_len);
      check(r_len <= bound, "R11 length bound", r_len, bound);
      check(r_done == 1, "R9 single done pulse", r_done, 1);
      check(fail == 1'b0, "R7 clean machine passes", fail, 0);
      check(!busy && !sym_valid, "R2 idle after run", {busy, sym_valid}, 0);
    end

    // start while busy
    run_exp(1, 1);
    check(r_len == exp_len && r_badpos < 0, "R10 mid-run start ignored", r_len, exp_len);

    // fault sweep over ordinary transitions
    for (int ix = 0; ix < N * M; ix++) begin
      f_idx = ix;
      if (tbl_out_ok[ix]) begin
        f_kind = 1; run_exp(ix % N, 0);
        check(fail == 1'b1, "R7 output fault detected", fail, 1);
      end
      if (tbl_next_ok[ix]) begin
        f_kind = 2; run_exp(ix % N, 0);
        check(fail == 1'b1, "R7 next-state fault detected", fail, 1);
      end
      if (!tbl_out_ok[ix] && !tbl_next_ok[ix]) begin
        f_kind = 1; run_exp(ix % N, 0);
        check(fail == 1'b0, "R6 unspecified pair not applied", fail, 0);
      end
    end

    // fault sweep over shift outputs
    for (int s = 0; s < N; s++) begin
      f_kind = 3; f_st = s;
      run_exp(0, 0);
      check(fail == 1'b1, "R7 shift output fault detected", fail, 1);
    end

    // stickiness and clear
    repeat (5) @(negedge clk);
    check(fail == 1'b1, "R8 fail holds while idle", fail, 1);
    f_kind = 0;
    run_exp(2, 0);
    check(fail == 1'b0, "R8 start clears fail", fail, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule